// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line that idles high. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. A free-running enable pulse, `tick16`, paces the receiver at sixteen pulses per bit time. The line first passes through a two-stage synchronizer. A single position counter then walks the frame in sixteenths of a bit and samples the line once per bit, at phase 7 of each bit.

A start edge that has gone high again by the middle of the start bit is treated as noise, and the receiver returns to idle. The received byte is copied to the output register at the middle of the stop bit. The frame closes three quarters of the way through the stop bit. This leaves about a quarter bit of slack for a sender running faster than the receiver, and it lets the next start edge be caught while the stop bit is still on the line.

A new byte is announced by inverting a flag, and only when the frame had a low start sample and a high stop sample. A consumer flag copies the receiver flag whenever the reader pulses `rd_ack`. The two flags differ while a byte is waiting, and their XOR drives the `byte_ready` level.

Top module: `serial_rx_oversampler`

## Requirements
- R1: A synchronous clear (`clr` high at a rising clock edge) sets `rx_byte` to 0, `byte_toggle` to 0 and `byte_ready` to 0, and returns the receiver to idle.
- R2: For a frame with a low start bit, data bits d0..d7 sent least significant bit first and a high stop bit, each bit lasting 16 `tick16` pulses, `rx_byte` afterwards equals the byte {d7..d0}. The line is used only after two register stages, and each bit is sampled at phase 7 of its 16 phases.
- R3: If the line is high again at the mid-start sample (position 7), the receiver returns to idle. `rx_byte` and `byte_toggle` are left unchanged.
- R4: `rx_byte` is loaded only at the mid-stop sample (position 0x97), and it is loaded whatever the stop level is.
- R5: `byte_toggle` inverts only when a frame closes with a high stop sample and a low start sample. A frame whose stop sample is low leaves `byte_toggle` unchanged.
- R6: A frame closes at position 0x9B, which is 12 of the 16 sixteenths into the stop bit. `byte_toggle` has therefore inverted before the stop bit ends, and a start bit that follows a 14-tick stop bit is received correctly.
- R7: `byte_ready` equals `byte_toggle` XOR a consumer flag. A one-cycle `rd_ack` copies `byte_toggle` into the consumer flag, so `byte_ready` goes low on the next cycle. An `rd_ack` with no byte pending leaves `byte_ready` low.
- R8: The receiver advances only on cycles where `tick16` is high. Holding `tick16` low during a frame, while the line is held steady, pauses the frame without corrupting it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| rx_line | input | 1 | Raw serial line, idle high, start bit low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rd_ack | input | 1 | One-cycle pulse when the consumer takes the byte |
| rx_byte | output | DATA_W | Last received data byte |
| byte_toggle | output | 1 | Inverts once per valid frame |
| byte_ready | output | 1 | High while a received byte is not yet acknowledged |

## Verification
The bench builds the block with its defaults: 8 data bits and 16 phases per bit. It drives `tick16` on every second clock, so one frame takes about 330 cycles. At that length all 256 byte values fit into a single run, each followed by an acknowledge. The same run also covers a start glitch, a low stop bit, a shortened stop bit followed by a back-to-back frame, and a pause of `tick16` in the middle of a bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Phase within a bit at which the line is sampled (middle of the bit).
  function automatic int mid_phase(input int ovs);
    return ovs / 2 - 1;
  endfunction

  // Position of the mid-stop sample: the stop bit follows start plus data.
  function automatic int stop_mid_pos(input int data_w, input int ovs);
    return (data_w + 1) * ovs + mid_phase(ovs);
  endfunction

  // Position at which a frame closes: three quarters into the stop bit.
  function automatic int stop_end_pos(input int data_w, input int ovs);
    return (data_w + 1) * ovs + (3 * ovs) / 4 - 1;
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (clr) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int POS_W  = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              tick,
  input  logic              line_s,
  output logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] data,
  output logic              end_evt,
  output logic              frame_ok
);
  localparam int PH_W  = $clog2(OVS);
  localparam int BUF_W = DATA_W + 2;
  localparam logic [PH_W-1:0]  MID_PH   = PH_W'(mid_phase(OVS));
  localparam logic [POS_W-1:0] START_MD = POS_W'(mid_phase(OVS));
  localparam logic [POS_W-1:0] STOP_MD  = POS_W'(stop_mid_pos(DATA_W, OVS));
  localparam logic [POS_W-1:0] STOP_END = POS_W'(stop_end_pos(DATA_W, OVS));

  logic [BUF_W-1:0] shbuf;
  logic             idle;
  logic             at_mid;

  assign idle   = (pos == '0);
  assign at_mid = (pos[PH_W-1:0] == MID_PH);

  always_ff @(posedge clk) begin
    if (clr) begin
      pos   <= '0;
      shbuf <= '1;
      data  <= '0;
    end else if (tick) begin
      if (idle) begin
        shbuf <= '1;
        if (!line_s) pos <= POS_W'(1);
      end else if (pos == STOP_END) begin
        pos <= '0;
      end else begin
        pos <= pos + POS_W'(1);
        if (at_mid) begin
          shbuf <= {line_s, shbuf[BUF_W-1:1]};
          if (pos == START_MD && line_s) pos <= '0;
          if (pos == STOP_MD) data <= shbuf[BUF_W-1:2];
        end
      end
    end
  end

  assign end_evt  = tick && (pos == STOP_END);
  assign frame_ok = shbuf[BUF_W-1] & ~shbuf[0];
endmodule

// File: rtl/serial_rx_handshake.sv
module serial_rx_handshake (
  input  logic clk,
  input  logic clr,
  input  logic end_evt,
  input  logic frame_ok,
  input  logic rd_ack,
  output logic rx_flag,
  output logic ready
);
  logic cons_flag;

  always_ff @(posedge clk) begin
    if (clr) begin
      rx_flag   <= 1'b0;
      cons_flag <= 1'b0;
    end else begin
      if (end_evt && frame_ok) rx_flag <= ~rx_flag;
      if (rd_ack) cons_flag <= rx_flag;
    end
  end

  assign ready = rx_flag ^ cons_flag;
endmodule

// File: rtl/serial_rx_oversampler.sv
module serial_rx_oversampler
  import serial_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_toggle,
  output logic              byte_ready
);
  localparam int POS_W = $clog2(stop_end_pos(DATA_W, OVS) + 1);

  logic             line_s;
  logic [POS_W-1:0] pos_q;
  logic             end_evt;
  logic             frame_ok;

  serial_rx_sync #(.STAGES(SYNC_ST)) sync_i (
    .clk(clk), .clr(clr), .din(rx_line), .dout(line_s)
  );

  serial_rx_framer #(.DATA_W(DATA_W), .OVS(OVS), .POS_W(POS_W)) framer_i (
    .clk(clk), .clr(clr), .tick(tick16), .line_s(line_s),
    .pos(pos_q), .data(rx_byte), .end_evt(end_evt), .frame_ok(frame_ok)
  );

  serial_rx_handshake hs_i (
    .clk(clk), .clr(clr), .end_evt(end_evt), .frame_ok(frame_ok),
    .rd_ack(rd_ack), .rx_flag(byte_toggle), .ready(byte_ready)
  );
endmodule

// File: rtl/serial_rx_oversampler_chk.sv
module serial_rx_oversampler_chk
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int POS_W  = 8
) (
  input logic              clk,
  input logic              clr,
  input logic              rx_line,
  input logic              tick16,
  input logic              rd_ack,
  input logic              line_s,
  input logic [POS_W-1:0]  pos,
  input logic [DATA_W-1:0] rx_byte,
  input logic              byte_toggle,
  input logic              byte_ready
);
  localparam logic [POS_W-1:0] START_MD = POS_W'(mid_phase(OVS));
  localparam logic [POS_W-1:0] STOP_MD  = POS_W'(stop_mid_pos(DATA_W, OVS));
  localparam logic [POS_W-1:0] STOP_END = POS_W'(stop_end_pos(DATA_W, OVS));

  // R1
  clear_state_chk: assert property (@(posedge clk)
    clr |=> (pos == '0) && !byte_toggle && !byte_ready);

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$past(clr, 2)) |-> line_s == $past(rx_line, 2));

  // R3
  false_start_chk: assert property (@(posedge clk) disable iff (clr)
    (tick16 && pos == START_MD && line_s) |=> pos == '0);

  // R4
  data_load_chk: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$stable(rx_byte)) |-> ($past(tick16) && $past(pos) == STOP_MD));

  // R5
  toggle_when_chk: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && !$stable(byte_toggle)) |-> ($past(tick16) && $past(pos) == STOP_END));

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (clr)
    pos <= STOP_END);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (clr)
    (rd_ack && !(tick16 && pos == STOP_END)) |=> !byte_ready);

  // R8
  tick_gate_chk: assert property (@(posedge clk) disable iff (clr)
    !tick16 |=> $stable(pos));
endmodule

bind serial_rx_oversampler serial_rx_oversampler_chk #(
  .DATA_W(DATA_W), .OVS(OVS), .POS_W(POS_W)
) chk_i (
  .clk(clk), .clr(clr), .rx_line(rx_line), .tick16(tick16), .rd_ack(rd_ack),
  .line_s(line_s), .pos(pos_q), .rx_byte(rx_byte),
  .byte_toggle(byte_toggle), .byte_ready(byte_ready)
);

// File: tb/serial_rx_oversampler_tb_top.sv
`timescale 1ns/1ps
module serial_rx_oversampler_tb_top;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic       tick_en = 1'b1;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_byte;
  logic       byte_toggle;
  logic       byte_ready;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_oversampler dut_i (
    .clk(clk), .clr(clr), .rx_line(rx_line), .tick16(tick16), .rd_ack(rd_ack),
    .rx_byte(rx_byte), .byte_toggle(byte_toggle), .byte_ready(byte_ready)
  );

  // tick16: one pulse every second clock while enabled
  initial begin
    forever begin
      @(negedge clk);
      tick16 = tick_en ? ~tick16 : 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b);
    rx_line = 1'b0;
    ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      ticks(16);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v, input int stop_ticks);
    send_bits(b);
    rx_line = stop_v;
    ticks(stop_ticks);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic prev_t;
    repeat (5) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check(rx_byte == 8'h00, "R1", "data after clear", rx_byte, 0);
    check(byte_toggle == 1'b0, "R1", "toggle after clear", byte_toggle, 0);
    check(byte_ready == 1'b0, "R1", "ready after clear", byte_ready, 0);

    // R7: acknowledge with nothing pending
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    check(byte_ready == 1'b0, "R7", "ready after idle ack", byte_ready, 0);

    // R2/R5/R7: every byte value
    for (int b = 0; b < 256; b++) begin
      prev_t = byte_toggle;
      send_frame(8'(b), 1'b1, 16);
      rx_line = 1'b1;
      ticks(2);
      check(rx_byte == 8'(b), "R2", "sweep data", rx_byte, b);
      check(byte_toggle == ~prev_t, "R5", "sweep toggle", byte_toggle, ~prev_t);
      check(byte_ready == 1'b1, "R7", "ready raised", byte_ready, 1);
      rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
      check(byte_ready == 1'b0, "R7", "ready after ack", byte_ready, 0);
    end

    // R6: early close, back-to-back frame after a 14-tick stop bit
    prev_t = byte_toggle;
    send_frame(8'hA5, 1'b1, 14);
    check(byte_toggle == ~prev_t, "R6", "toggle inside stop bit", byte_toggle, ~prev_t);
    check(rx_byte == 8'hA5, "R6", "first data", rx_byte, 8'hA5);
    send_frame(8'h3C, 1'b1, 16);
    rx_line = 1'b1;
    ticks(2);
    check(rx_byte == 8'h3C, "R6", "back-to-back data", rx_byte, 8'h3C);
    check(byte_toggle == prev_t, "R6", "two toggles", byte_toggle, prev_t);

    // R3: start glitch shorter than half a bit
    prev_t = byte_toggle;
    rx_line = 1'b0; ticks(4); rx_line = 1'b1; ticks(200);
    check(byte_toggle == prev_t, "R3", "toggle after glitch", byte_toggle, prev_t);
    check(rx_byte == 8'h3C, "R3", "data after glitch", rx_byte, 8'h3C);

    // R4/R5: low stop bit loads data but raises no flag
    prev_t = byte_toggle;
    send_frame(8'h5A, 1'b0, 16);
    rx_line = 1'b1;
    ticks(200);
    check(rx_byte == 8'h5A, "R4", "data with low stop", rx_byte, 8'h5A);
    check(byte_toggle == prev_t, "R5", "no toggle on low stop", byte_toggle, prev_t);

    // R8: pause tick16 in the middle of a data bit
    prev_t = byte_toggle;
    rx_line = 1'b0; ticks(16);
    for (int i = 0; i < 8; i++) begin
      rx_line = 1'((8'hC6 >> i) & 1);
      if (i == 4) begin
        ticks(8);
        tick_en = 1'b0;
        repeat (40) @(negedge clk);
        tick_en = 1'b1;
        ticks(8);
      end else begin
        ticks(16);
      end
    end
    rx_line = 1'b1; ticks(18);
    check(rx_byte == 8'hC6, "R8", "data after pause", rx_byte, 8'hC6);
    check(byte_toggle == ~prev_t, "R8", "toggle after pause", byte_toggle, ~prev_t);

    // R1: clear after activity
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    check(rx_byte == 8'h00, "R1", "data after late clear", rx_byte, 0);
    check(byte_toggle == 1'b0, "R1", "toggle after late clear", byte_toggle, 0);
    check(byte_ready == 1'b0, "R1", "ready after late clear", byte_ready, 0);

    finish_run();
  end
endmodule